// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Prescaler

This block derives a system clock by dividing a source clock by an integer between one and eight. A bypass select chooses the source. When the select is low, the source is the multiplied clock. When it is high, the source is the raw oscillator clock. Division applies the same way in both cases.

The divisor comes from a small code field. The code is brought into the source-clock domain through a synchronizer. It is accepted only after two consecutive synchronized samples agree. An accepted divisor is loaded only when the output period in progress finishes. Software can therefore change the rate while the clock runs, and every output high or low phase still belongs wholly to the old rate or to the new one.

Divide-by-one passes the selected source straight through. The bypass select is a static strap: it may change only while reset is asserted.

Top module: `glitchfree_prescaler`

## Requirements
- R1: The divisor N equals the code value plus one. Code 000 gives N=1 and code 111 gives N=8. For a settled code, each output period lasts N source cycles.
- R2: With code 000, the output follows the selected source clock: high for half a source cycle, low for the other half.
- R3: Reset loads divisor 8, whatever the code input. The first output period after reset lasts 8 source cycles, with a 4-cycle high phase, even when the code input already holds another value.
- R4: A new divisor is loaded only at the end of the output period in progress. Every high phase and every low phase around a change matches either the old divisor or the new one.
- R5: With bypass high, the oscillator clock is divided. With bypass low, the multiplied clock is divided. Bypass changes only while reset is asserted.
- R6: All eight divisors behave identically in bypass mode and in multiplied mode.
- R7: For N of 2 or more, the output is high for floor(N/2) source cycles at the start of each period and low for the remaining cycles.
- R8: A code value present on the input for only one source-clock edge is ignored; the output keeps the rate already in force.
- R9: While reset is asserted, the output is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mult | input | 1 | Multiplied source clock, selected when bypass is low |
| clk_osc | input | 1 | Raw oscillator clock, selected when bypass is high |
| bypass | input | 1 | Source select, static outside reset |
| div_code | input | CODE_W | Divisor code, N = code + 1, asynchronous to both clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_out | output | 1 | Divided system clock |

## Verification
The bench steps through every ordered pair of divisor codes on the multiplied clock. After each change it measures every output high and low phase against the two allowed widths. A design that loaded a new divisor in mid-period would produce a phase that matches neither width, and so would one that switched glitchily into or out of pass-through.

A separate check holds the code input at a non-default value through reset. It expects an eight-cycle first period, which catches a wrong reset value or an unsynchronized code path. Single-edge code pulses are injected to show that a synchronizer without the stability filter would let a transient rate through. Bypass mode is swept with the slower oscillator period, which catches a source mux wired the wrong way round.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
   // Limits checked when the prescaler is elaborated.
   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MAX_CODE_W      = 6;
endpackage

// File: rtl/prescale_src_mux.sv
// Static source selection; the select is a strap that only moves under reset.
module prescale_src_mux (
   input  logic clk_a,
   input  logic clk_b,
   input  logic sel_b,
   output logic clk_sel
);
   assign clk_sel = sel_b ? clk_b : clk_a;
endmodule

// File: rtl/prescale_code_sync.sv
// Reset release and divisor code capture in the source domain.
module prescale_code_sync #(
   parameter int CODE_W = 3,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic [CODE_W-1:0] code_in,
   output logic              rst_n_out,
   output logic [CODE_W-1:0] code_out
);
   logic [STAGES-1:0] rst_pipe;
   logic [CODE_W-1:0] stg [STAGES+1];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) rst_pipe <= '0;
      else         rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
   end
   assign rst_n_out = rst_pipe[STAGES-1];

   // Synchronizer chain plus one compare stage; all reset to the divide-by-max code.
   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n_out) begin
            if (!rst_n_out) stg[i] <= '1;
            else            stg[i] <= code_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n_out) begin
            if (!rst_n_out) stg[i] <= '1;
            else            stg[i] <= stg[i-1];
         end
      end
   end

   // Accept only a value that two successive synchronized samples agree on.
   always_ff @(posedge clk or negedge rst_n_out) begin
      if (!rst_n_out)                          code_out <= '1;
      else if (stg[STAGES] == stg[STAGES-1])   code_out <= stg[STAGES];
   end

   // R8: the accepted code only moves to a value held over two sampled edges
   a_r8_accept_stable: assert property (@(posedge clk) disable iff (!rst_n_out)
      !$stable(code_out) |-> ($past(stg[STAGES-1]) == code_out));
endmodule

// File: rtl/prescale_divider.sv
// Counter-based divider with period-boundary reload and pass-through for N=1.
module prescale_divider #(
   parameter int CODE_W = 3
) (
   input  logic              src_clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   output logic              clk_out
);
   localparam logic [CODE_W:0] ONE = {{CODE_W{1'b0}}, 1'b1};

   logic [CODE_W-1:0] cur_code;
   logic [CODE_W-1:0] cnt;
   logic              pass_q;
   logic              hi_q;
   logic              boundary;
   logic [CODE_W:0]   cnt_inc;
   logic [CODE_W:0]   hi_len;

   // Period ends when the count reaches N-1, which equals the code itself.
   assign boundary = pass_q || (cnt == cur_code);
   assign cnt_inc  = {1'b0, cnt} + ONE;
   assign hi_len   = ({1'b0, cur_code} + ONE) >> 1;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_code <= '1;
         cnt      <= '1;
         pass_q   <= 1'b0;
         hi_q     <= 1'b0;
      end else if (boundary) begin
         cur_code <= code;
         cnt      <= '0;
         pass_q   <= (code == '0);
         hi_q     <= (code != '0);
      end else begin
         cnt      <= cnt_inc[CODE_W-1:0];
         hi_q     <= (cnt_inc < hi_len);
      end
   end

   // The select only changes on a rising source edge at a period boundary.
   assign clk_out = pass_q ? src_clk : hi_q;

   // R4: the count never runs past the period of the divisor in force
   a_r4_cnt_in_period: assert property (@(posedge src_clk) disable iff (!rst_n)
      !pass_q |-> (cnt <= cur_code));
   // R7: the high phase starts at the first cycle of a period
   a_r7_rise_at_start: assert property (@(posedge src_clk) disable iff (!rst_n)
      $rose(hi_q) |-> (cnt == '0));
   // R7: the high phase ends after floor(N/2) cycles
   a_r7_fall_at_half: assert property (@(posedge src_clk) disable iff (!rst_n)
      $fell(hi_q) && !pass_q |-> ({1'b0, cnt} == hi_len));
   // R2: pass-through only while divide-by-one is in force
   a_r2_pass_code0: assert property (@(posedge src_clk) disable iff (!rst_n)
      pass_q |-> (cur_code == '0));
endmodule

// File: rtl/glitchfree_prescaler.sv
module glitchfree_prescaler
   import prescaler_pkg::*;
#(
   parameter int CODE_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_mult,
   input  logic              clk_osc,
   input  logic              bypass,
   input  logic [CODE_W-1:0] div_code,
   input  logic              rst_n,
   output logic              clk_out
);
   if (CODE_W < 1 || CODE_W > int'(MAX_CODE_W)) begin : g_bad_width
      $error("prescaler: CODE_W out of range");
   end
   if (SYNC_STAGES < int'(MIN_SYNC_STAGES)) begin : g_bad_sync
      $error("prescaler: SYNC_STAGES too small");
   end

   logic              src_clk;
   logic              src_rst_n;
   logic [CODE_W-1:0] acc_code;

   prescale_src_mux i_mux (
      .clk_a   (clk_mult),
      .clk_b   (clk_osc),
      .sel_b   (bypass),
      .clk_sel (src_clk)
   );

   prescale_code_sync #(.CODE_W(CODE_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk       (src_clk),
      .arst_n    (rst_n),
      .code_in   (div_code),
      .rst_n_out (src_rst_n),
      .code_out  (acc_code)
   );

   prescale_divider #(.CODE_W(CODE_W)) i_div (
      .src_clk (src_clk),
      .rst_n   (src_rst_n),
      .code    (acc_code),
      .clk_out (clk_out)
   );
endmodule

// File: tb/test_glitchfree_prescaler.sv
`timescale 1ns/1ps
module test_glitchfree_prescaler;
   logic       clk_mult = 1'b0;
   logic       clk_osc  = 1'b0;
   logic       bypass   = 1'b0;
   logic [2:0] div_code = 3'd0;
   logic       rst_n    = 1'b0;
   logic       clk_out;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  mon_on   = 1'b0;
   bit  have_rise = 1'b0;
   bit  have_fall = 1'b0;
   real t_rise = 0.0;
   real t_fall = 0.0;
   int  alw_a = 0;
   int  alw_b = 0;
   real src_t = 4.0;
   string cur_tag = "R4";

   glitchfree_prescaler i_glitchfree_prescaler (
      .clk_mult (clk_mult),
      .clk_osc  (clk_osc),
      .bypass   (bypass),
      .div_code (div_code),
      .rst_n    (rst_n),
      .clk_out  (clk_out)
   );

   initial forever #2 clk_mult = ~clk_mult;
   initial begin
      #1.3;
      forever #5 clk_osc = ~clk_osc;
   end

   function automatic real hi_of(int code, real t);
      if (code == 0) return t / 2.0;
      return real'((code + 1) / 2) * t;
   endfunction

   function automatic real lo_of(int code, real t);
      if (code == 0) return t / 2.0;
      return real'((code + 1) - (code + 1) / 2) * t;
   endfunction

   function automatic bit near(real a, real b);
      return (a - b < 0.01) && (b - a < 0.01);
   endfunction

   task automatic check_phase(string tag, string which, real got, real ea, real eb);
      n_checks++;
      if (!(near(got, ea) || near(got, eb))) begin
         n_fails++;
         $display("FAIL %s %s phase: actual %0.3f ns, expected %0.3f or %0.3f ns",
                  tag, which, got, ea, eb);
      end
   endtask

   task automatic check_real(string tag, string what, real got, real exp);
      n_checks++;
      if (!near(got, exp)) begin
         n_fails++;
         $display("FAIL %s %s: actual %0.3f, expected %0.3f", tag, what, got, exp);
      end
   endtask

   task automatic check_bit(string tag, logic got, logic exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s output level: actual %b, expected %b", tag, got, exp);
      end
   endtask

   // Phase monitor: every completed phase must match one of the allowed divisors.
   always @(posedge clk_out) begin
      if (mon_on) begin
         if (have_fall)
            check_phase(cur_tag, "low", $realtime - t_fall,
                        lo_of(alw_a, src_t), lo_of(alw_b, src_t));
         t_rise    = $realtime;
         have_rise = 1'b1;
      end
   end

   always @(negedge clk_out) begin
      if (mon_on) begin
         if (have_rise)
            check_phase(cur_tag, "high", $realtime - t_rise,
                        hi_of(alw_a, src_t), hi_of(alw_b, src_t));
         t_fall    = $realtime;
         have_fall = 1'b1;
      end
   end

   task automatic wait_src(int n);
      for (int i = 0; i < n; i++) begin
         if (bypass) @(negedge clk_osc);
         else        @(negedge clk_mult);
      end
   endtask

   int cur = 0;

   task automatic step(int code);
      string steady;
      if (bypass)         steady = "R5/R6";
      else if (code == 0) steady = "R2";
      else                steady = "R1/R7";
      wait_src(1);
      cur_tag  = "R4";
      alw_a    = cur;
      alw_b    = code;
      div_code = 3'(code);
      wait_src(48);
      cur_tag  = steady;
      alw_a    = code;
      alw_b    = code;
      wait_src(24);
      cur = code;
   endtask

   task automatic run_mode(bit byp);
      real t0, t1, t2;
      mon_on   = 1'b0;
      rst_n    = 1'b0;
      #1.1;
      bypass   = byp;
      src_t    = byp ? 10.0 : 4.0;
      div_code = 3'd0;
      for (int i = 0; i < 5; i++) begin
         #3.1;
         check_bit("R9", clk_out, 1'b0);  // R9: low in reset
      end
      #0.7;
      rst_n = 1'b1;
      // R3: first period uses divide-by-8 although the input holds code 000
      @(posedge clk_out); t0 = $realtime;
      @(negedge clk_out); t1 = $realtime;
      @(posedge clk_out); t2 = $realtime;
      check_real("R3", "first high", t1 - t0, 4.0 * src_t);
      check_real("R3", "first low",  t2 - t1, 4.0 * src_t);
      cur   = 0;
      alw_a = 0;
      alw_b = 0;
      wait_src(8);
      have_rise = 1'b0;
      have_fall = 1'b0;
      cur_tag   = byp ? "R5/R6" : "R2";
      mon_on    = 1'b1;
   endtask

   initial begin
      // Multiplied source: every ordered pair of divisor codes (R1, R2, R4, R7).
      run_mode(1'b0);
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            step(a);
            step(b);
         end
      end
      // R8: single-edge code pulses must not change the rate.
      step(3);
      cur_tag = "R8";
      for (int p = 0; p < 8; p++) begin
         if (p != 3) begin
            @(negedge clk_mult) div_code = 3'(p);
            @(negedge clk_mult) div_code = 3'd3;
            wait_src(40);
         end
      end
      // Oscillator source: sweep up and down (R5, R6).
      run_mode(1'b1);
      for (int c = 0; c < 8; c++) step(c);
      for (int c = 7; c >= 0; c--) step(c);
      mon_on = 1'b0;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      #400000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end
endmodule